// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, every clock, which of several hardware thread contexts feeds the next instruction into a shared pipeline. It has two scheduling modes. In interleaved mode it rotates through the threads one per clock in round-robin order and passes over any thread that reports a stall. In switch-on-miss mode it stays with one thread and only moves away when that thread signals an expensive stall, such as a miss in the second-level cache. Every such move costs a drain cycle plus a programmable number of refill cycles.

An optional preferred thread can be named. When the preference is enabled and that thread is ready, it wins the interleaved slot, and it is the first choice whenever a switch-on-miss move picks a new thread. The block only makes the selection. Register files, program counters, fetch and caches belong to the surrounding pipeline. The outputs are combinational from the inputs and the stored state, so they apply to the current cycle.

Top module: `issue_thread_selector`

## Requirements
- R1: After reset the current thread is 0 and the rotation pointer is 0. The first interleaved grant with all threads ready is therefore thread 0, with flush_req low and refill_left 0.
- R2: In interleaved mode (mode_coarse=0), the grant is the first thread whose thr_stall bit is 0, searching upward from the rotation pointer and wrapping past the highest ID. A stalled thread is never granted.
- R3: After each interleaved grant the pointer moves to the granted ID plus one, modulo the thread count. With exactly two threads ready, the grants alternate between them on every cycle.
- R4: In interleaved mode with every thread stalled, sel_valid is 0 and the rotation pointer keeps its value.
- R5: In interleaved mode with pref_en=1 and thread pref_tid not stalled, sel_tid is pref_tid and sel_valid is 1.
- R6: In switch-on-miss mode (mode_coarse=1), sel_tid shows the current thread. sel_valid is 1 exactly when that thread is not stalled and no drain or refill is under way. A plain stall, or a long-stall event carrying another thread's ID, does not change the current thread.
- R7: A long-stall event for the current thread, arriving while it is issuing, raises flush_req for that one cycle, with sel_valid 0.
- R8: The thread chosen after a drain is pref_tid if pref_en=1 and that thread is ready and is not the thread that missed. Otherwise it is the first ready thread after the missed one in ascending wrapped order, never the missed one itself. The pointer becomes the chosen ID plus one.
- R9: If no thread qualifies at the drain, the block waits with sel_valid 0 and no flush. Each cycle it searches again from the missed ID plus one, and this time the missed thread is considered last.
- R10: Once a new thread is chosen, sel_valid stays 0 for refill_cycles cycles while refill_left counts down from refill_cycles to 1. Issue then resumes. A refill count of 0 lets the new thread issue on the very next cycle. refill_left reads 0 in interleaved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_stall | input | NUM_THR | Per-thread stall flag, bit i for thread i |
| long_stall_evt | input | 1 | Expensive stall reported this cycle |
| long_stall_tid | input | TID_W | Thread that reported the expensive stall |
| mode_coarse | input | 1 | 0 = interleave every clock, 1 = switch on miss |
| pref_en | input | 1 | Enable preferred-thread priority |
| pref_tid | input | TID_W | Preferred thread ID |
| refill_cycles | input | REFILL_W | Refill bubble length after a switch |
| sel_tid | output | TID_W | Thread selected for issue |
| sel_valid | output | 1 | Selected thread issues this cycle |
| flush_req | output | 1 | Drain request for the pipeline on a switch |
| refill_left | output | REFILL_W | Refill cycles still to run |

## Verification
The bench builds the block with its defaults: four threads and a 3-bit refill count. With these values the interleaved sweep can try every one of the 16 stall patterns from every pointer position, under each preference setting. The switch-on-miss run draws pseudo-random stall densities and events. This reaches every refill length from 0 to 7, waits with all threads stalled, preferred-thread picks at drain time, and mode changes in the middle of a refill, all compared cycle by cycle with a reference model kept in the bench.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;

  // Switch-on-miss phase: issuing/refilling, or searching for a ready thread
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_WAIT = 1'b1
  } cphase_t;

  // Wrapped addition over a thread count
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction

endpackage

// File: rtl/tsu_rr_pick.sv
`timescale 1ns/1ps
module tsu_rr_pick #(
  parameter int NUM_THR = 4,
  localparam int TID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic [NUM_THR-1:0] req,
  input  logic [TID_W-1:0]   start,
  output logic               found,
  output logic [TID_W-1:0]   pick
);
  import tsu_pkg::*;

  logic [NUM_THR-1:0] rot;

  // rot[k] is the request of the thread k places after start
  for (genvar k = 0; k < NUM_THR; k++) begin : g_rot
    assign rot[k] = req[wrap_add(int'(start), k, NUM_THR)];
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = NUM_THR - 1; k >= 0; k--) begin
      if (rot[k]) begin
        found = 1'b1;
        pick  = TID_W'(wrap_add(int'(start), k, NUM_THR));
      end
    end
  end

endmodule

// File: rtl/tsu_refill_timer.sv
`timescale 1ns/1ps
module tsu_refill_timer #(
  parameter int REFILL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [REFILL_W-1:0] load_val,
  output logic [REFILL_W-1:0] cnt,
  output logic                busy
);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/issue_thread_selector.sv
`timescale 1ns/1ps
module issue_thread_selector #(
  parameter int NUM_THR  = 4,
  parameter int REFILL_W = 3,
  localparam int TID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_THR-1:0]  thr_stall,
  input  logic                long_stall_evt,
  input  logic [TID_W-1:0]    long_stall_tid,
  input  logic                mode_coarse,
  input  logic                pref_en,
  input  logic [TID_W-1:0]    pref_tid,
  input  logic [REFILL_W-1:0] refill_cycles,
  output logic [TID_W-1:0]    sel_tid,
  output logic                sel_valid,
  output logic                flush_req,
  output logic [REFILL_W-1:0] refill_left
);
  import tsu_pkg::*;

  function automatic logic [TID_W-1:0] tid_next(logic [TID_W-1:0] t);
    return TID_W'(wrap_add(int'(t), 1, NUM_THR));
  endfunction

  logic [TID_W-1:0] cur_q, rr_q;
  cphase_t          phase_q;

  logic [NUM_THR-1:0] ready;
  logic [NUM_THR-1:0] cur_oh;
  logic [NUM_THR-1:0] sw_mask;

  // Interleaved candidate
  logic             fine_found;
  logic [TID_W-1:0] fine_pick;
  logic             pref_hit_fine;
  logic [TID_W-1:0] fine_grant;

  // Switch-on-miss candidate
  logic             sw_found_rr;
  logic [TID_W-1:0] sw_pick;
  logic             pref_hit_sw;
  logic             sw_found;
  logic [TID_W-1:0] sw_tid;

  // Named internal events
  logic                refill_busy;
  logic [REFILL_W-1:0] tmr_cnt;
  logic                run_slot;
  logic                long_hit;
  logic                seek;
  logic                switch_go;
  logic                tmr_load;
  logic [REFILL_W-1:0] tmr_val;

  assign ready  = ~thr_stall;
  assign cur_oh = NUM_THR'(1) << cur_q;

  tsu_rr_pick #(.NUM_THR(NUM_THR)) u_fine_pick (
    .req   (ready),
    .start (rr_q),
    .found (fine_found),
    .pick  (fine_pick)
  );

  assign pref_hit_fine = pref_en && ready[pref_tid];
  assign fine_grant    = pref_hit_fine ? pref_tid : fine_pick;

  // At the drain the missed thread is excluded; while waiting it comes last
  assign sw_mask = (phase_q == PH_WAIT) ? ready : (ready & ~cur_oh);

  tsu_rr_pick #(.NUM_THR(NUM_THR)) u_sw_pick (
    .req   (sw_mask),
    .start (tid_next(cur_q)),
    .found (sw_found_rr),
    .pick  (sw_pick)
  );

  assign pref_hit_sw = pref_en && sw_mask[pref_tid];
  assign sw_found    = sw_found_rr;
  assign sw_tid      = pref_hit_sw ? pref_tid : sw_pick;

  tsu_refill_timer #(.REFILL_W(REFILL_W)) u_refill (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .busy     (refill_busy)
  );

  assign run_slot  = (phase_q == PH_RUN) && !refill_busy;
  assign long_hit  = mode_coarse && run_slot && long_stall_evt && (long_stall_tid == cur_q);
  assign seek      = mode_coarse && (long_hit || (phase_q == PH_WAIT));
  assign switch_go = seek && sw_found;
  assign tmr_load  = !mode_coarse || switch_go;
  assign tmr_val   = mode_coarse ? refill_cycles : '0;

  assign sel_tid     = mode_coarse ? cur_q : fine_grant;
  assign sel_valid   = mode_coarse ? (run_slot && !long_hit && ready[cur_q]) : fine_found;
  assign flush_req   = long_hit;
  assign refill_left = mode_coarse ? tmr_cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      rr_q    <= '0;
      phase_q <= PH_RUN;
    end else if (!mode_coarse) begin
      phase_q <= PH_RUN;
      if (fine_found) begin
        cur_q <= fine_grant;
        rr_q  <= tid_next(fine_grant);
      end
    end else if (switch_go) begin
      cur_q   <= sw_tid;
      rr_q    <= tid_next(sw_tid);
      phase_q <= PH_RUN;
    end else if (seek) begin
      phase_q <= PH_WAIT;
    end
  end

endmodule

// File: rtl/tsu_checker.sv
`timescale 1ns/1ps
module tsu_checker #(
  parameter int NUM_THR  = 4,
  parameter int REFILL_W = 3,
  localparam int TID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_THR-1:0]  thr_stall,
  input logic                mode_coarse,
  input logic                pref_en,
  input logic [TID_W-1:0]    pref_tid,
  input logic [TID_W-1:0]    sel_tid,
  input logic                sel_valid,
  input logic                flush_req,
  input logic [REFILL_W-1:0] refill_left
);

  AST_FINE_SKIPS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && sel_valid) |-> !thr_stall[sel_tid]); // R2

  AST_FINE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && (&thr_stall)) |-> !sel_valid); // R4

  AST_PREF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && pref_en && !thr_stall[pref_tid]) |-> (sel_valid && sel_tid == pref_tid)); // R5

  AST_COARSE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_coarse && sel_valid) |=> (!(mode_coarse && sel_valid) || sel_tid == $past(sel_tid))); // R6

  AST_FLUSH_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !sel_valid); // R7

  AST_REFILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_left != '0) |-> !sel_valid); // R10

  AST_REFILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_coarse && refill_left > REFILL_W'(1)) |=>
      (!mode_coarse || refill_left == $past(refill_left) - 1'b1)); // R10

endmodule

bind issue_thread_selector tsu_checker #(.NUM_THR(NUM_THR), .REFILL_W(REFILL_W)) u_tsu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr_stall   (thr_stall),
  .mode_coarse (mode_coarse),
  .pref_en     (pref_en),
  .pref_tid    (pref_tid),
  .sel_tid     (sel_tid),
  .sel_valid   (sel_valid),
  .flush_req   (flush_req),
  .refill_left (refill_left)
);

// File: tb/test_issue_thread_selector.sv
`timescale 1ns/1ps
module test_issue_thread_selector;

  localparam int NT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] thr_stall = 4'h0;
  logic       long_stall_evt = 1'b0;
  logic [1:0] long_stall_tid = 2'd0;
  logic       mode_coarse = 1'b0;
  logic       pref_en = 1'b0;
  logic [1:0] pref_tid = 2'd0;
  logic [2:0] refill_cycles = 3'd0;
  logic [1:0] sel_tid;
  logic       sel_valid;
  logic       flush_req;
  logic [2:0] refill_left;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  issue_thread_selector i_issue_thread_selector (
    .clk            (clk),
    .rst_n          (rst_n),
    .thr_stall      (thr_stall),
    .long_stall_evt (long_stall_evt),
    .long_stall_tid (long_stall_tid),
    .mode_coarse    (mode_coarse),
    .pref_en        (pref_en),
    .pref_tid       (pref_tid),
    .refill_cycles  (refill_cycles),
    .sel_tid        (sel_tid),
    .sel_valid      (sel_valid),
    .flush_req      (flush_req),
    .refill_left    (refill_left)
  );

  // Reference model state
  int m_rr, m_cur, m_cnt;
  bit m_wait, m_fresh;
  int n_rr, n_cur, n_cnt;
  bit n_wait, n_fresh;
  int e_tid, e_left;
  bit e_valid, e_flush;
  string e_tag;

  task automatic model_reset();
    m_rr = 0; m_cur = 0; m_cnt = 0; m_wait = 0; m_fresh = 0;
  endtask

  // Expected outputs for the current inputs and the state after the edge
  task automatic predict();
    bit rdy [NT];
    int nready = 0;
    bit got = 0;
    int g = 0;
    for (int i = 0; i < NT; i++) begin
      rdy[i] = !thr_stall[i];
      if (rdy[i]) nready++;
    end
    n_rr = m_rr; n_cur = m_cur; n_cnt = m_cnt; n_wait = m_wait; n_fresh = m_fresh;
    e_flush = 0; e_left = 0;
    if (!mode_coarse) begin
      if (pref_en && rdy[pref_tid]) begin
        got = 1; g = pref_tid;
      end else begin
        for (int k = 0; k < NT; k++)
          if (!got && rdy[(m_rr + k) % NT]) begin got = 1; g = (m_rr + k) % NT; end
      end
      e_valid = got; e_tid = g;
      if (!got) e_tag = "R4";
      else if (pref_en && rdy[pref_tid]) e_tag = "R5";
      else if (nready == 2) e_tag = "R3";
      else e_tag = "R2";
      if (got) begin n_cur = g; n_rr = (g + 1) % NT; end
      n_wait = 0; n_cnt = 0; n_fresh = 0;
    end else begin
      bit running = !m_wait && (m_cnt == 0);
      bit hit = running && long_stall_evt && (int'(long_stall_tid) == m_cur);
      e_tid = m_cur; e_left = m_cnt; e_flush = hit;
      e_valid = running && !hit && rdy[m_cur];
      if (hit) e_tag = "R7";
      else if (m_wait) e_tag = "R9";
      else if (m_cnt > 0) e_tag = "R10";
      else if (m_fresh) e_tag = "R8";
      else e_tag = "R6";
      n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (e_valid) n_fresh = 0;
      if (hit || m_wait) begin
        int lim = m_wait ? NT : NT - 1;
        if (pref_en && rdy[pref_tid] && (m_wait || int'(pref_tid) != m_cur)) begin
          got = 1; g = pref_tid;
        end else begin
          for (int k = 1; k <= lim; k++)
            if (!got && rdy[(m_cur + k) % NT]) begin got = 1; g = (m_cur + k) % NT; end
        end
        if (got) begin
          n_cur = g; n_rr = (g + 1) % NT; n_cnt = refill_cycles; n_wait = 0; n_fresh = 1;
        end else begin
          n_wait = 1;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    total++;
    if (sel_valid !== e_valid || flush_req !== e_flush || int'(refill_left) != e_left ||
        ((mode_coarse || e_valid) && int'(sel_tid) != e_tid)) begin
      bad++;
      $display("FAIL %s: got tid=%0d valid=%0d flush=%0d left=%0d, expected tid=%0d valid=%0d flush=%0d left=%0d",
               tag, sel_tid, sel_valid, flush_req, refill_left, e_tid, e_valid, e_flush, e_left);
    end
  endtask

  // One cycle: inputs already driven after a falling edge
  task automatic cycle(string force_tag);
    #1;
    predict();
    compare(force_tag == "" ? e_tag : force_tag);
    @(posedge clk);
    m_rr = n_rr; m_cur = n_cur; m_cnt = n_cnt; m_wait = n_wait; m_fresh = n_fresh;
    @(negedge clk);
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] lfsr_step(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first interleaved grant after reset with all ready is thread 0
    thr_stall = 4'h0;
    cycle("R1");
    cycle("R1");

    // R2 R3 R4 R5: every stall pattern at every pointer, each preference setting
    for (int p = 0; p <= NT; p++) begin
      pref_en  = (p < NT);
      pref_tid = 2'(p % NT);
      for (int rep = 0; rep < NT; rep++)
        for (int s = 0; s < 16; s++) begin
          thr_stall = 4'(s);
          cycle("");
        end
    end

    // R3: two ready threads alternate
    pref_en = 1'b0;
    thr_stall = 4'b1010;
    for (int i = 0; i < 6; i++) cycle("R3");

    // R6..R10: switch-on-miss under pseudo-random stall density and events
    mode_coarse = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      lf = lfsr_step(lf);
      if (i % 1500 < 750) thr_stall = lf[3:0] & lf[7:4];
      else                thr_stall = lf[3:0] | lf[7:4];
      long_stall_evt = (lf[10:8] == 3'd0) || (lf[10:8] == 3'd5);
      long_stall_tid = lf[11] ? 2'(m_cur) : lf[13:12];
      refill_cycles  = lf[15:13];
      pref_en        = lf[9] & lf[14];
      pref_tid       = lf[6:5];
      if (lf[15:9] == 7'd3) mode_coarse = ~mode_coarse;
      else if (lf[15:9] == 7'd77) mode_coarse = 1'b1;
      cycle("");
    end

    long_stall_evt = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule